// File: doc/BRIEF.md
# Event Interrupt Pacer

This block turns a stream of single-cycle completion pulses into a thinned-out interrupt pulse. It holds two small state machines side by side. The tally machine counts events. The delay machine measures time in prescaler ticks from the first event of a batch. A paced pulse goes out when either machine reaches its threshold, whichever comes first under the current configuration. After each pulse both machines begin a new batch.

A 32-bit configuration word sets the block. Bits 27:16 hold the tick threshold and bits 15:8 hold the event threshold. Bit 2 enables the tally path and bit 3 enables the delay path. Bit 0 holds the tally path cleared and bit 1 holds the delay path cleared. A status word shows the phase and the live values of both machines. It is a plain combinational view of the state, so watching it changes nothing. A design holds one instance for each event source, and the pulses go to a downstream combiner.

Top module: `evt_pacer`

## Requirements
- R1: While reset is held and in the first cycle after it, `evt_out` is 0 and `status` is all zero.
- R2: With only the tally path on and an event threshold N ≥ 2, `evt_out` is high for one cycle, in the cycle after the clock edge that samples the N-th event of a batch. Every cycle of a batch, the tally field of `status` shows the number of events seen so far.
- R3: With the tally path on and an event threshold of 0 or 1, each sampled event gives a pulse in the next cycle. Nothing accumulates.
- R4: In a pulse cycle, both machines are in phase FIRE with zero values. An event sampled during that cycle starts the next batch with a tally of 1, so it is not lost.
- R5: With only the delay path on and a tick threshold T ≥ 1, the pulse comes one cycle after the edge that samples the T-th tick after the first event. A tick sampled together with that first event does not count. The timer field advances by one on each tick while a batch is open.
- R6: With both paths on, the pulse comes from whichever threshold is reached first. Both tally and timer then restart from zero.
- R7: A tick threshold of 0 disables the delay path. Its phase and timer stay zero and it never causes a pulse.
- R8: Clearing an enable bit (bit 2 for tally, bit 3 for delay) sends that machine to IDLE with a zero value. With both bits clear, no pulse is produced.
- R9: While a clear bit is set (bit 0 for tally, bit 1 for delay), that machine stays IDLE at zero and ignores events and ticks.
- R10: The `status` fields are laid out as follows. Bits 1:0 hold the tally phase and bits 3:2 the delay phase, each coded IDLE=0, RUN=1, FIRE=2. Bits 11:4 hold the tally and bits 23:12 the timer. With no event and no tick, `status` holds steady.
- R11: An event sampled on the same edge as the expiring tick belongs to the batch that pulse closes. The next cycle after the pulse is IDLE with zero tally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 1 | Single-cycle completion event |
| tick_in | input | 1 | Prescaler tick |
| cfg | input | 32 | Thresholds, enables and clears |
| status | output | 24 | Phases, tally and timer |
| evt_out | output | 1 | Paced single-cycle pulse |

## Verification
Every result depends on a single registered stage. The pulse and all status fields take on the outcome of a sampled event or tick one cycle after the edge that samples it. The bench applies stimulus 1 ns after a rising edge and compares at 1 ns after the following edge, so each compare sees exactly one edge's effect. The reference model computes its next state from the same inputs before that edge. It is compared in every cycle of every sweep, and short directed sequences pin the exact cycle of each threshold crossing.

// File: rtl/evt_pacer_pkg.sv
package evt_pacer_pkg;
  localparam int CFG_W     = 32;
  localparam int TIME_LSB  = 16;
  localparam int COUNT_LSB = 8;
  localparam int CLR_TALLY = 0;
  localparam int CLR_DELAY = 1;
  localparam int EN_TALLY  = 2;
  localparam int EN_DELAY  = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIRE = 2'd2
  } phase_e;
endpackage

// File: rtl/evt_pacer_decode.sv
module evt_pacer_decode
  import evt_pacer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TIM_W = 12
) (
  input  logic [CFG_W-1:0] cfg,
  output logic             tally_on,
  output logic             delay_on,
  output logic [CNT_W-1:0] tally_thr,
  output logic [TIM_W-1:0] delay_thr
);
  localparam int TIME_MSB  = TIME_LSB + TIM_W - 1;
  localparam int COUNT_MSB = COUNT_LSB + CNT_W - 1;

  always_comb begin
    tally_thr = cfg[COUNT_MSB:COUNT_LSB];
    delay_thr = cfg[TIME_MSB:TIME_LSB];
    tally_on  = cfg[EN_TALLY] && !cfg[CLR_TALLY];
    delay_on  = cfg[EN_DELAY] && !cfg[CLR_DELAY] && (delay_thr != '0);
  end
endmodule

// File: rtl/evt_pacer_tally.sv
module evt_pacer_tally
  import evt_pacer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             evt,
  input  logic             fire,
  input  logic [CNT_W-1:0] thr,
  output logic             hit,
  output phase_e           phase,
  output logic [CNT_W-1:0] tally
);
  localparam int EXT_W = CNT_W + 1;

  function automatic logic [EXT_W-1:0] next_tally(phase_e ph, logic [CNT_W-1:0] cur);
    if (ph == PH_RUN) return {1'b0, cur} + EXT_W'(1);
    return EXT_W'(1);
  endfunction

  function automatic logic reached(logic [EXT_W-1:0] t, logic [CNT_W-1:0] limit);
    return t >= {1'b0, limit};
  endfunction

  logic [EXT_W-1:0] tally_inc;

  always_comb begin
    tally_inc = next_tally(phase, tally);
    hit       = enable && evt && reached(tally_inc, thr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      phase <= PH_IDLE;
      tally <= '0;
    end else if (fire) begin
      phase <= PH_FIRE;
      tally <= '0;
    end else if (evt) begin
      phase <= PH_RUN;
      tally <= tally_inc[CNT_W-1:0];
    end else if (phase == PH_FIRE) begin
      phase <= PH_IDLE;
      tally <= '0;
    end
  end
endmodule

// File: rtl/evt_pacer_delay.sv
module evt_pacer_delay
  import evt_pacer_pkg::*;
#(
  parameter int TIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             evt,
  input  logic             tick,
  input  logic             fire,
  input  logic [TIM_W-1:0] thr,
  output logic             hit,
  output phase_e           phase,
  output logic [TIM_W-1:0] timer
);
  localparam int EXT_W = TIM_W + 1;

  function automatic logic expired(logic [TIM_W-1:0] cur, logic [TIM_W-1:0] limit);
    return ({1'b0, cur} + EXT_W'(1)) >= {1'b0, limit};
  endfunction

  always_comb hit = enable && (phase == PH_RUN) && tick && expired(timer, thr);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      phase <= PH_IDLE;
      timer <= '0;
    end else if (fire) begin
      phase <= PH_FIRE;
      timer <= '0;
    end else if (phase == PH_RUN) begin
      if (tick) timer <= timer + TIM_W'(1);
    end else if (evt) begin
      phase <= PH_RUN;
      timer <= '0;
    end else if (phase == PH_FIRE) begin
      phase <= PH_IDLE;
    end
  end
endmodule

// File: rtl/evt_pacer.sv
module evt_pacer
  import evt_pacer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TIM_W = 12,
  localparam int STAT_W = 4 + CNT_W + TIM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_in,
  input  logic              tick_in,
  input  logic [CFG_W-1:0]  cfg,
  output logic [STAT_W-1:0] status,
  output logic              evt_out
);
  logic             tally_on, delay_on;
  logic [CNT_W-1:0] tally_thr, tally_val;
  logic [TIM_W-1:0] delay_thr, timer_val;
  logic             tally_hit, delay_hit, fire;
  phase_e           tally_ph, delay_ph;

  evt_pacer_decode #(.CNT_W(CNT_W), .TIM_W(TIM_W)) u_decode (
    .cfg       (cfg),
    .tally_on  (tally_on),
    .delay_on  (delay_on),
    .tally_thr (tally_thr),
    .delay_thr (delay_thr)
  );

  evt_pacer_tally #(.CNT_W(CNT_W)) u_tally (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (tally_on),
    .evt    (evt_in),
    .fire   (fire),
    .thr    (tally_thr),
    .hit    (tally_hit),
    .phase  (tally_ph),
    .tally  (tally_val)
  );

  evt_pacer_delay #(.TIM_W(TIM_W)) u_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (delay_on),
    .evt    (evt_in),
    .tick   (tick_in),
    .fire   (fire),
    .thr    (delay_thr),
    .hit    (delay_hit),
    .phase  (delay_ph),
    .timer  (timer_val)
  );

  assign fire = tally_hit || delay_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) evt_out <= 1'b0;
    else        evt_out <= fire;
  end

  assign status = {timer_val, tally_val, delay_ph, tally_ph};
endmodule

// File: rtl/evt_pacer_chk.sv
module evt_pacer_chk
  import evt_pacer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TIM_W = 12,
  localparam int STAT_W = 4 + CNT_W + TIM_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_in,
  input logic              tick_in,
  input logic [CFG_W-1:0]  cfg,
  input logic [STAT_W-1:0] status,
  input logic              evt_out,
  input logic              tally_hit,
  input logic              delay_hit
);
  logic [1:0]       s_tph, s_dph;
  logic [CNT_W-1:0] s_tally;
  logic [TIM_W-1:0] s_timer;
  assign s_tph   = status[1:0];
  assign s_dph   = status[3:2];
  assign s_tally = status[4 +: CNT_W];
  assign s_timer = status[4+CNT_W +: TIM_W];

  p_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_out |-> ($past(evt_in) || $past(tick_in)));

  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[EN_TALLY] && !cfg[CLR_TALLY] && cfg[COUNT_LSB +: CNT_W] <= 1 && evt_in) |=> evt_out);

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_out |-> (s_tally == '0 && s_timer == '0));

  p_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    delay_hit |-> tick_in);

  p_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cfg[EN_TALLY] && !cfg[EN_DELAY])) |-> !evt_out);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg[CLR_TALLY]) |-> (s_tally == '0 && s_tph == 2'd0));

  p_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tph != 2'd3) && (s_dph != 2'd3));

  p_tally_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tally_hit |-> evt_in);
endmodule

bind evt_pacer evt_pacer_chk #(.CNT_W(CNT_W), .TIM_W(TIM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_in    (evt_in),
  .tick_in   (tick_in),
  .cfg       (cfg),
  .status    (status),
  .evt_out   (evt_out),
  .tally_hit (tally_hit),
  .delay_hit (delay_hit)
);

// File: tb/evt_pacer_tb.sv
module evt_pacer_tb;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_in = 1'b0;
  logic        tick_in = 1'b0;
  logic [31:0] cfg = '0;
  logic [23:0] status;
  logic        evt_out;

  int vectors = 0;
  int fails = 0;
  string tag = "R1";

  int  m_cs, m_c, m_ts, m_t;
  bit  m_out;

  always #(HALF) clk = ~clk;

  evt_pacer u_dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .tick_in(tick_in),
    .cfg(cfg), .status(status), .evt_out(evt_out)
  );

  function automatic logic [31:0] mk(int tthr, int cthr, bit den, bit ten, bit dclr, bit tclr);
    return (32'(tthr) << 16) | (32'(cthr) << 8) | (32'(den) << 3) | (32'(ten) << 2)
         | (32'(dclr) << 1) | 32'(tclr);
  endfunction

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic do_reset(logic [31:0] c);
    rst_n = 1'b0; cfg = c; evt_in = 0; tick_in = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    m_cs = 0; m_c = 0; m_ts = 0; m_t = 0; m_out = 0;
    chk("R1 status", 32'(status), 32'd0);
    chk("R1 out", 32'(evt_out), 32'd0);
  endtask

  task automatic cyc(bit e, bit t);
    int cthr, tthr, nc;
    bit con, ton, ch, th, fr;
    logic [23:0] exp;
    cthr = int'(cfg[15:8]);
    tthr = int'(cfg[27:16]);
    con  = cfg[2] && !cfg[0];
    ton  = cfg[3] && !cfg[1] && (tthr != 0);
    nc   = (m_cs == 1) ? m_c + 1 : 1;
    ch   = con && e && (nc >= cthr);
    th   = ton && (m_ts == 1) && t && (m_t + 1 >= tthr);
    fr   = ch || th;
    if (!con)            begin m_cs = 0; m_c = 0; end
    else if (fr)         begin m_cs = 2; m_c = 0; end
    else if (e)          begin m_cs = 1; m_c = nc; end
    else if (m_cs == 2)  begin m_cs = 0; m_c = 0; end
    if (!ton)            begin m_ts = 0; m_t = 0; end
    else if (fr)         begin m_ts = 2; m_t = 0; end
    else if (m_ts == 1)  begin if (t) m_t = m_t + 1; end
    else if (e)          begin m_ts = 1; m_t = 0; end
    else if (m_ts == 2)  begin m_ts = 0; end
    m_out = fr;
    evt_in = e; tick_in = t;
    @(posedge clk);
    #1 evt_in = 0; tick_in = 0;
    exp = {m_t[11:0], m_c[7:0], m_ts[1:0], m_cs[1:0]};
    chk({tag, " out"}, 32'(evt_out), 32'(m_out));
    chk({tag, " status"}, 32'(status), 32'(exp));
  endtask

  initial begin
    #(HALF * 2 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    tag = "R1";
    do_reset('0);

    // R2: tally only, thresholds 2..6, three event spacings
    tag = "R2";
    for (int n = 2; n <= 6; n++)
      for (int g = 1; g <= 3; g++) begin
        do_reset(mk(0, n, 0, 1, 0, 0));
        for (int i = 0; i < 30; i++) cyc((i % g) == 0, 1'b0);
      end

    // R3: pass-through thresholds
    tag = "R3";
    for (int n = 0; n <= 1; n++)
      for (int g = 1; g <= 2; g++) begin
        do_reset(mk(0, n, 0, 1, 0, 0));
        for (int i = 0; i < 12; i++) begin
          cyc((i % g) == 0, 1'b0);
          if ((i % g) == 0) chk("R3 pulse", 32'(evt_out), 32'd1);
        end
      end

    // R4: event in the pulse cycle opens the next batch
    tag = "R4";
    do_reset(mk(0, 3, 0, 1, 0, 0));
    cyc(1, 0); cyc(1, 0); cyc(1, 0);
    chk("R4 pulse", 32'(evt_out), 32'd1);
    chk("R4 fire phase", 32'(status[1:0]), 32'd2);
    cyc(1, 0);
    chk("R4 tally 1", 32'(status[11:4]), 32'd1);
    chk("R4 run", 32'(status[1:0]), 32'd1);

    // R5: delay only, thresholds 1..5, tick spacings 1..3
    tag = "R5";
    for (int tt = 1; tt <= 5; tt++)
      for (int p = 1; p <= 3; p++) begin
        do_reset(mk(tt, 0, 1, 0, 0, 0));
        for (int i = 0; i < 30; i++) cyc((i % 11) == 0, (i % p) == 0);
      end
    do_reset(mk(3, 0, 1, 0, 0, 0));
    cyc(1, 1); cyc(0, 1); cyc(0, 1);
    chk("R5 not yet", 32'(evt_out), 32'd0);
    chk("R5 timer 2", 32'(status[23:12]), 32'd2);
    cyc(0, 1);
    chk("R5 pulse", 32'(evt_out), 32'd1);

    // R6: both paths, whichever first
    tag = "R6";
    for (int g = 1; g <= 4; g++)
      for (int p = 1; p <= 3; p++) begin
        do_reset(mk(4, 3, 1, 1, 0, 0));
        for (int i = 0; i < 40; i++) cyc((i % g) == 0, (i % p) == 1);
      end

    // R7: zero tick threshold disables the delay path
    tag = "R7";
    do_reset(mk(0, 0, 1, 0, 0, 0));
    for (int i = 0; i < 10; i++) begin
      cyc(1, 1);
      chk("R7 silent", 32'(evt_out), 32'd0);
    end

    // R8: enables dropped mid-batch
    tag = "R8";
    do_reset(mk(5, 4, 1, 1, 0, 0));
    cyc(1, 0); cyc(1, 1);
    cfg = mk(5, 4, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) cyc(1, 1);
    chk("R8 idle", 32'(status), 32'd0);
    cfg = mk(5, 4, 0, 1, 0, 0);
    for (int i = 0; i < 6; i++) cyc(1, 0);

    // R9: clear bits hold machines idle
    tag = "R9";
    do_reset(mk(2, 2, 1, 1, 1, 1));
    for (int i = 0; i < 8; i++) cyc(1, 1);
    chk("R9 held", 32'(status), 32'd0);
    cfg = mk(2, 2, 1, 1, 0, 1);
    for (int i = 0; i < 8; i++) cyc((i % 3) == 0, 1);

    // R10: field layout and hold without stimulus
    tag = "R10";
    do_reset(mk(0, 5, 0, 1, 0, 0));
    cyc(1, 0); cyc(1, 0);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0);
      chk("R10 layout", 32'(status), 32'h21);
    end

    // R11: event on the expiring tick belongs to the closed batch
    tag = "R11";
    do_reset(mk(2, 0, 1, 0, 0, 0));
    cyc(1, 0); cyc(0, 1); cyc(1, 1);
    chk("R11 pulse", 32'(evt_out), 32'd1);
    chk("R11 fire", 32'(status[3:2]), 32'd2);
    cyc(0, 0);
    chk("R11 idle", 32'(status), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule